// File: doc/BRIEF.md
# Linear-Buffer SPI Flash Command Engine

This block issues single SPI flash commands on behalf of software through a small byte-wide register window. Software loads an opcode, a send count, a receive count and up to 71 payload bytes placed straight into a flat byte buffer, then sets a launch bit. The engine drops chip select, shifts out the opcode followed by the payload, clocks in the requested number of response bytes, and raises chip select again. The launch bit reads as one for the whole transaction and clears itself when the engine is done.

Response bytes are written back into the same buffer, in the slots that directly follow the payload. The slot index wraps modulo the buffer size, so a long payload followed by a response can wrap back to slot 0. A 16-bit clock-code register holds four 4-bit rate codes. Only the top nibble sets the SPI clock for command transfers; the engine decodes it into a half-period count of system clocks. Launching only works while the engine-enable bit is set.

Top module: `spi_linbuf_engine`

## Requirements
- R1: After reset every register and buffer byte reads 0, spi_cs_n is high and spi_sck is low.
- R2: The opcode register (0x00) reads back as a full byte. The engine-enable register (0x20) keeps only bit 0 and reads other bits as 0. The clock-code register is split into a low byte at 0x22 and a high byte at 0x23, and both read back as written.
- R3: A write of the send count (0x48) above 71 stores 71. A write of the receive count (0x4B) above 68 stores 68. Smaller values are kept as written.
- R4: Writing 1 to bit 0 of 0x02 while enable is 1 starts a transaction. Bit 0 of 0x02 then reads 1 until the transaction ends, after which it reads 0. When enable is 0, the write is ignored: the bit stays 0 and chip select stays high.
- R5: During a transaction chip select stays low throughout. The bytes on spi_mosi are the opcode, then buffer slots 0 to send-count-1, then one zero byte per receive byte. Each byte goes out MSB first in SPI mode 0 (clock idles low, data sampled on the rising edge). Exactly 8*(1+send+receive) rising clock edges occur.
- R6: The i-th response byte, sampled from spi_miso, is stored in buffer slot (send count + i) mod 71.
- R7: For the SPI clock, only bits 15:12 of the clock-code register count. With the default 200 MHz system clock, the high and low phases of spi_sck each last this many system clocks: code 4 gives 1, code 0 gives 2, code 1 gives 4, code 2 gives 5, code 3 gives 7, and code 7 gives 125. Every other code (5, 6, 8 to 15) also gives 125.
- R8: While a transaction is in progress, bus writes to every register and to the buffer have no effect.
- R9: The buffer occupies addresses 0x80 to 0xC6, one byte per address, with slot k at 0x80+k. Writes to unmapped addresses have no effect, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Byte write strobe for the register window |
| bus_addr | input | 8 | Byte address in the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bound checker runs on every cycle and covers these rules:
- chip select is only low while the launch bit is set, and the serial clock is quiet while chip select is high;
- the stored counts never exceed their limits;
- a launch only happens with enable set;
- the opcode, counts and enable stay frozen for as long as a transaction runs;
- the decoded half-period is always one of the six legal values.

Some things only the bench scenarios can show, by watching the wire and reading the buffer back: the byte order on spi_mosi, the wrapped placement of response bytes, the measured clock phase lengths for each code, and the clamping and ignore rules.

// File: rtl/spi_le_pkg.sv
package spi_le_pkg;

    // Software-visible byte offsets (software depends on these)
    localparam logic [7:0] A_OPCODE   = 8'h00;
    localparam logic [7:0] A_LAUNCH   = 8'h02;
    localparam logic [7:0] A_ENABLE   = 8'h20;
    localparam logic [7:0] A_RATE_LO  = 8'h22;
    localparam logic [7:0] A_RATE_HI  = 8'h23;
    localparam logic [7:0] A_SENDCNT  = 8'h48;
    localparam logic [7:0] A_RECVCNT  = 8'h4B;
    localparam logic [7:0] A_BUFBASE  = 8'h80;

    typedef enum logic [1:0] {X_IDLE = 2'd0, X_SHIFT = 2'd1, X_FIN = 2'd2} xstate_e;
    typedef enum logic [1:0] {PH_OPC = 2'd0, PH_SEND = 2'd1, PH_RECV = 2'd2} phase_e;

    typedef enum logic [3:0] {
        RATE_66M  = 4'd0,
        RATE_33M  = 4'd1,
        RATE_22M  = 4'd2,
        RATE_16M5 = 4'd3,
        RATE_100M = 4'd4,
        RATE_800K = 4'd7
    } rate_e;

    function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
        return (a + b - 1) / b;
    endfunction

    // System clocks per SPI clock phase, rounded up so the SPI clock never runs fast
    function automatic int unsigned half_for(input int unsigned clk_khz, input int unsigned spi_khz);
        return ceil_div(clk_khz, 2 * spi_khz);
    endfunction

endpackage

// File: rtl/spi_le_rate.sv
module spi_le_rate
    import spi_le_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 200000,
    parameter int unsigned HALF_W  = 7
) (
    input  logic [3:0]        code,
    output logic [HALF_W-1:0] half
);
    localparam int unsigned H100 = half_for(CLK_KHZ, 100000);
    localparam int unsigned H66  = half_for(CLK_KHZ, 66000);
    localparam int unsigned H33  = half_for(CLK_KHZ, 33000);
    localparam int unsigned H22  = half_for(CLK_KHZ, 22000);
    localparam int unsigned H16  = half_for(CLK_KHZ, 16500);
    localparam int unsigned H08  = half_for(CLK_KHZ, 800);

    always_comb begin
        case (code)
            RATE_100M: half = HALF_W'(H100);
            RATE_66M:  half = HALF_W'(H66);
            RATE_33M:  half = HALF_W'(H33);
            RATE_22M:  half = HALF_W'(H22);
            RATE_16M5: half = HALF_W'(H16);
            default:   half = HALF_W'(H08);   // 800 kHz and every reserved code
        endcase
    end
endmodule

// File: rtl/spi_le_regs.sv
module spi_le_regs
    import spi_le_pkg::*;
#(
    parameter  int unsigned BUF_BYTES = 71,
    parameter  int unsigned RX_MAX    = 68,
    localparam int unsigned IDX_W     = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [7:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             xfer_done,
    input  logic             eng_wr_en,
    input  logic [IDX_W-1:0] eng_wr_idx,
    input  logic [7:0]       eng_wr_byte,
    input  logic [IDX_W-1:0] eng_rd_idx,
    output logic [7:0]       eng_rd_byte,
    output logic             start,
    output logic             go,
    output logic             enable,
    output logic [7:0]       opcode,
    output logic [7:0]       send_cnt,
    output logic [7:0]       recv_cnt,
    output logic [3:0]       rate_code
);
    localparam logic [7:0] TX_LIM = 8'(BUF_BYTES);
    localparam logic [7:0] RX_LIM = 8'(RX_MAX);

    typedef struct packed {
        logic [BUF_BYTES-1:0][7:0] mem;
        logic [7:0]                opcode;
        logic [7:0]                send;
        logic [7:0]                recv;
        logic [15:0]               rate;
        logic                      en;
        logic                      go;
    } regs_t;

    regs_t s_q, s_d;

    logic [7:0]       buf_off;
    logic             in_buf;
    logic [IDX_W-1:0] buf_idx;

    assign buf_off = bus_addr - A_BUFBASE;
    assign in_buf  = (bus_addr >= A_BUFBASE) && (buf_off < TX_LIM);
    assign buf_idx = buf_off[IDX_W-1:0];

    always_comb begin
        s_d   = s_q;
        start = 1'b0;
        if (xfer_done) begin
            s_d.go = 1'b0;
        end
        if (eng_wr_en) begin
            s_d.mem[eng_wr_idx] = eng_wr_byte;
        end
        if (bus_we && !s_q.go) begin
            if (in_buf) begin
                s_d.mem[buf_idx] = bus_wdata;
            end else begin
                case (bus_addr)
                    A_OPCODE:  s_d.opcode = bus_wdata;
                    A_LAUNCH: begin
                        if (bus_wdata[0] && s_q.en) begin
                            s_d.go = 1'b1;
                            start  = 1'b1;
                        end
                    end
                    A_ENABLE:  s_d.en         = bus_wdata[0];
                    A_RATE_LO: s_d.rate[7:0]  = bus_wdata;
                    A_RATE_HI: s_d.rate[15:8] = bus_wdata;
                    A_SENDCNT: s_d.send = (bus_wdata > TX_LIM) ? TX_LIM : bus_wdata;
                    A_RECVCNT: s_d.recv = (bus_wdata > RX_LIM) ? RX_LIM : bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (in_buf) begin
            bus_rdata = s_q.mem[buf_idx];
        end else begin
            case (bus_addr)
                A_OPCODE:  bus_rdata = s_q.opcode;
                A_LAUNCH:  bus_rdata = {7'b0, s_q.go};
                A_ENABLE:  bus_rdata = {7'b0, s_q.en};
                A_RATE_LO: bus_rdata = s_q.rate[7:0];
                A_RATE_HI: bus_rdata = s_q.rate[15:8];
                A_SENDCNT: bus_rdata = s_q.send;
                A_RECVCNT: bus_rdata = s_q.recv;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign eng_rd_byte = s_q.mem[eng_rd_idx];
    assign go          = s_q.go;
    assign enable      = s_q.en;
    assign opcode      = s_q.opcode;
    assign send_cnt    = s_q.send;
    assign recv_cnt    = s_q.recv;
    assign rate_code   = s_q.rate[15:12];
endmodule

// File: rtl/spi_le_xfer.sv
module spi_le_xfer
    import spi_le_pkg::*;
#(
    parameter  int unsigned BUF_BYTES = 71,
    parameter  int unsigned HALF_W    = 7,
    localparam int unsigned IDX_W     = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [7:0]        send_cnt,
    input  logic [7:0]        recv_cnt,
    input  logic [HALF_W-1:0] half,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [7:0]        rd_byte,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [7:0]        wr_byte,
    output logic              done,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    typedef struct packed {
        xstate_e           st;
        phase_e            ph;
        logic [HALF_W-1:0] cnt;
        logic [HALF_W-1:0] half;
        logic              sck;
        logic              cs_n;
        logic              mosi;
        logic [2:0]        bitn;
        logic [7:0]        sh;
        logic [7:0]        rcv;
        logic [7:0]        sendl;
        logic [7:0]        recvl;
        logic [IDX_W-1:0]  ptr;
    } xfer_t;

    xfer_t x_q, x_d;
    logic [7:0] sendl_nx, recvl_nx;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(BUF_BYTES - 1)) ? '0 : p + IDX_W'(1);
    endfunction

    always_comb begin
        x_d      = x_q;
        wr_en    = 1'b0;
        wr_idx   = x_q.ptr;
        wr_byte  = x_q.rcv;
        sendl_nx = x_q.sendl;
        recvl_nx = x_q.recvl;
        case (x_q.st)
            X_IDLE: begin
                if (start) begin
                    x_d.st    = X_SHIFT;
                    x_d.ph    = PH_OPC;
                    x_d.cs_n  = 1'b0;
                    x_d.sck   = 1'b0;
                    x_d.cnt   = '0;
                    x_d.half  = half;
                    x_d.bitn  = 3'd7;
                    x_d.sh    = opcode;
                    x_d.mosi  = opcode[7];
                    x_d.ptr   = '0;
                    x_d.sendl = send_cnt;
                    x_d.recvl = recv_cnt;
                end
            end
            X_SHIFT: begin
                if (x_q.cnt != x_q.half - HALF_W'(1)) begin
                    x_d.cnt = x_q.cnt + HALF_W'(1);
                end else begin
                    x_d.cnt = '0;
                    if (!x_q.sck) begin
                        // rising edge: sample the flash
                        x_d.sck = 1'b1;
                        x_d.rcv = {x_q.rcv[6:0], miso};
                    end else begin
                        // falling edge: present next bit
                        x_d.sck = 1'b0;
                        if (x_q.bitn != 3'd0) begin
                            x_d.bitn = x_q.bitn - 3'd1;
                            x_d.sh   = {x_q.sh[6:0], 1'b0};
                            x_d.mosi = x_q.sh[6];
                        end else begin
                            x_d.bitn = 3'd7;
                            if (x_q.ph == PH_RECV) begin
                                wr_en    = 1'b1;
                                x_d.ptr  = step(x_q.ptr);
                                recvl_nx = x_q.recvl - 8'd1;
                            end
                            if (x_q.ph == PH_SEND) begin
                                sendl_nx = x_q.sendl - 8'd1;
                            end
                            x_d.sendl = sendl_nx;
                            x_d.recvl = recvl_nx;
                            if (x_q.ph != PH_RECV && sendl_nx != 8'd0) begin
                                x_d.ph   = PH_SEND;
                                x_d.sh   = rd_byte;
                                x_d.mosi = rd_byte[7];
                                x_d.ptr  = step(x_q.ptr);
                            end else if (recvl_nx != 8'd0) begin
                                x_d.ph   = PH_RECV;
                                x_d.sh   = '0;
                                x_d.mosi = 1'b0;
                            end else begin
                                x_d.st   = X_FIN;
                                x_d.cs_n = 1'b1;
                                x_d.mosi = 1'b0;
                            end
                        end
                    end
                end
            end
            X_FIN: begin
                x_d.st = X_IDLE;
            end
            default: x_d.st = X_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q      <= '0;
            x_q.cs_n <= 1'b1;
        end else begin
            x_q <= x_d;
        end
    end

    assign rd_idx = x_q.ptr;
    assign done   = (x_q.st == X_FIN);
    assign sck    = x_q.sck;
    assign cs_n   = x_q.cs_n;
    assign mosi   = x_q.mosi;
endmodule

// File: rtl/spi_linbuf_engine.sv
module spi_linbuf_engine
    import spi_le_pkg::*;
#(
    parameter int unsigned CLK_KHZ   = 200000,
    parameter int unsigned BUF_BYTES = 71,
    parameter int unsigned RX_MAX    = 68
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_sck,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    localparam int unsigned HALF_MAX = half_for(CLK_KHZ, 800);
    localparam int unsigned HALF_W   = $clog2(HALF_MAX + 1);
    localparam int unsigned IDX_W    = $clog2(BUF_BYTES);

    logic             start_w, go_w, en_w, done_w;
    logic [7:0]       opcode_w, send_w, recv_w;
    logic [3:0]       code_w;
    logic [HALF_W-1:0] half_w;
    logic             ewr_en;
    logic [IDX_W-1:0] ewr_idx, erd_idx;
    logic [7:0]       ewr_byte, erd_byte;

    spi_le_regs #(.BUF_BYTES(BUF_BYTES), .RX_MAX(RX_MAX)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .xfer_done  (done_w),
        .eng_wr_en  (ewr_en),
        .eng_wr_idx (ewr_idx),
        .eng_wr_byte(ewr_byte),
        .eng_rd_idx (erd_idx),
        .eng_rd_byte(erd_byte),
        .start      (start_w),
        .go         (go_w),
        .enable     (en_w),
        .opcode     (opcode_w),
        .send_cnt   (send_w),
        .recv_cnt   (recv_w),
        .rate_code  (code_w)
    );

    spi_le_rate #(.CLK_KHZ(CLK_KHZ), .HALF_W(HALF_W)) rate_i (
        .code(code_w),
        .half(half_w)
    );

    spi_le_xfer #(.BUF_BYTES(BUF_BYTES), .HALF_W(HALF_W)) xfer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_w),
        .opcode  (opcode_w),
        .send_cnt(send_w),
        .recv_cnt(recv_w),
        .half    (half_w),
        .rd_idx  (erd_idx),
        .rd_byte (erd_byte),
        .wr_en   (ewr_en),
        .wr_idx  (ewr_idx),
        .wr_byte (ewr_byte),
        .done    (done_w),
        .sck     (spi_sck),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );
endmodule

// File: rtl/spi_le_chk.sv
module spi_le_chk
    import spi_le_pkg::*;
#(
    parameter int unsigned TX_MAX  = 71,
    parameter int unsigned RX_MAX  = 68,
    parameter int unsigned CLK_KHZ = 200000,
    parameter int unsigned HALF_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_sck,
    input logic              go,
    input logic              en,
    input logic [7:0]        opcode,
    input logic [7:0]        send_cnt,
    input logic [7:0]        recv_cnt,
    input logic [HALF_W-1:0] half
);
    localparam logic [HALF_W-1:0] L0 = HALF_W'(half_for(CLK_KHZ, 100000));
    localparam logic [HALF_W-1:0] L1 = HALF_W'(half_for(CLK_KHZ, 66000));
    localparam logic [HALF_W-1:0] L2 = HALF_W'(half_for(CLK_KHZ, 33000));
    localparam logic [HALF_W-1:0] L3 = HALF_W'(half_for(CLK_KHZ, 22000));
    localparam logic [HALF_W-1:0] L4 = HALF_W'(half_for(CLK_KHZ, 16500));
    localparam logic [HALF_W-1:0] L5 = HALF_W'(half_for(CLK_KHZ, 800));

    p_cs_needs_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !go |-> spi_cs_n);

    p_start_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go) |-> $past(en));

    p_sck_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    p_count_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (send_cnt <= 8'(TX_MAX)) && (recv_cnt <= 8'(RX_MAX)));

    p_frozen_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && $past(go)) |-> ($stable(opcode) && $stable(send_cnt) && $stable(recv_cnt) && $stable(en)));

    p_rate_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (half == L0) || (half == L1) || (half == L2) || (half == L3) || (half == L4) || (half == L5));
endmodule

bind spi_linbuf_engine spi_le_chk #(
    .TX_MAX (BUF_BYTES),
    .RX_MAX (RX_MAX),
    .CLK_KHZ(CLK_KHZ),
    .HALF_W (HALF_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .spi_cs_n(spi_cs_n),
    .spi_sck (spi_sck),
    .go      (go_w),
    .en      (en_w),
    .opcode  (opcode_w),
    .send_cnt(send_w),
    .recv_cnt(recv_w),
    .half    (half_w)
);

// File: tb/spi_linbuf_engine_tb_top.sv
module spi_linbuf_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi, spi_miso;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    spi_linbuf_engine dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- flash model ----------------
    function automatic logic [7:0] rbyte(input int j);
        return 8'(8'h3C ^ (j * 29));
    endfunction
    function automatic logic rbit(input int k);
        logic [7:0] b;
        b = rbyte(k / 8);
        return b[7 - (k % 8)];
    endfunction

    int         rises = 0;
    logic [7:0] mosi_sh = '0;
    logic [7:0] cap [0:255];
    always @(posedge spi_sck or negedge spi_cs_n) begin
        if (spi_sck) begin
            mosi_sh = {mosi_sh[6:0], spi_mosi};
            rises   = rises + 1;
            if (rises % 8 == 0) cap[rises / 8 - 1] = mosi_sh;
        end else begin
            rises = 0;
        end
    end
    assign spi_miso = rbit(rises);

    bit mon_clr = 1'b0;
    int hi_cnt = 0;
    always @(posedge clk) begin
        if (mon_clr) hi_cnt <= 0;
        else if (!spi_cs_n && spi_sck) hi_cnt <= hi_cnt + 1;
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic int exp_half(input logic [3:0] c);
        case (c)
            4'd4: return 1;
            4'd0: return 2;
            4'd1: return 4;
            4'd2: return 5;
            4'd3: return 7;
            default: return 125;
        endcase
    endfunction

    function automatic logic [7:0] pay(input int vi, input int k);
        return 8'(k * 7 + vi * 13 + 1);
    endfunction

    task automatic wait_idle(output int loops);
        logic [7:0] v;
        loops = 0;
        do begin
            rd(8'h02, v);
            loops++;
        end while (v[0] && loops < 20000);
    endtask

    // {opcode, send, recv, rate code}
    localparam int NV = 8;
    localparam logic [31:0] VEC [NV] = '{
        {8'h9F, 8'd0,  8'd3,  8'd4},
        {8'h03, 8'd3,  8'd4,  8'd0},
        {8'h02, 8'd5,  8'd0,  8'd1},
        {8'h0B, 8'd70, 8'd3,  8'd4},   // response wraps to slots 70,0,1
        {8'h5A, 8'd71, 8'd2,  8'd2},   // full payload, response at 0,1
        {8'h06, 8'd0,  8'd0,  8'd3},
        {8'hAB, 8'd1,  8'd68, 8'd4},
        {8'h05, 8'd0,  8'd1,  8'd5}    // reserved code
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int loops;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 cs_n", int'(spi_cs_n), 1);
        check("R1 sck", int'(spi_sck), 0);
        begin
            logic [7:0] addrs [8] = '{8'h00, 8'h02, 8'h20, 8'h22, 8'h23, 8'h48, 8'h4B, 8'h80};
            for (int i = 0; i < 8; i++) begin
                rd(addrs[i], v);
                check($sformatf("R1 reg 0x%02h", addrs[i]), v, 0);
            end
        end

        // R2 readback
        wr(8'h00, 8'hA7); rd(8'h00, v); check("R2 opcode", v, 8'hA7);
        wr(8'h20, 8'hFF); rd(8'h20, v); check("R2 enable bit0 only", v, 1);
        wr(8'h22, 8'h5C); rd(8'h22, v); check("R2 rate low", v, 8'h5C);
        wr(8'h23, 8'hE1); rd(8'h23, v); check("R2 rate high", v, 8'hE1);

        // R3 clamping
        wr(8'h48, 8'd200); rd(8'h48, v); check("R3 send clamp", v, 71);
        wr(8'h48, 8'd71);  rd(8'h48, v); check("R3 send at limit", v, 71);
        wr(8'h4B, 8'd100); rd(8'h4B, v); check("R3 recv clamp", v, 68);
        wr(8'h4B, 8'd69);  rd(8'h4B, v); check("R3 recv just over", v, 68);
        wr(8'h4B, 8'd68);  rd(8'h4B, v); check("R3 recv at limit", v, 68);

        // R9 buffer window edges
        wr(8'hC6, 8'h3D); rd(8'hC6, v); check("R9 last slot", v, 8'h3D);
        wr(8'hC7, 8'h55); rd(8'hC7, v); check("R9 past buffer", v, 0);
        wr(8'h01, 8'h66); rd(8'h01, v); check("R9 unmapped", v, 0);

        // R4 launch ignored while disabled
        wr(8'h20, 8'h00);
        mon_clr = 1'b1;
        wr(8'h02, 8'h01);
        rd(8'h02, v); check("R4 launch ignored when disabled", v, 0);
        begin
            int low = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (!spi_cs_n) low++;
            end
            check("R4 cs stays high when disabled", low, 0);
        end
        wr(8'h20, 8'h01);

        // Vector table walk: R5, R6, R7, R4
        for (int vi = 0; vi < NV; vi++) begin
            logic [7:0] op, snd, rcv, code;
            int errs;
            {op, snd, rcv, code} = VEC[vi];
            for (int k = 0; k < 71; k++) wr(8'(8'h80 + k), pay(vi, k));
            wr(8'h23, {code[3:0], 4'h1});
            wr(8'h22, 8'h1C);
            wr(8'h00, op);
            wr(8'h48, snd);
            wr(8'h4B, rcv);
            mon_clr = 1'b1;
            @(negedge clk);
            mon_clr = 1'b0;
            wr(8'h02, 8'h01);
            rd(8'h02, v); check($sformatf("R4 busy flag v%0d", vi), v, 1);
            wait_idle(loops);
            check($sformatf("R4 launch clears v%0d", vi), int'(loops < 20000), 1);
            check($sformatf("R5 edge count v%0d", vi), rises, 8 * (1 + snd + rcv));
            check($sformatf("R5 opcode v%0d", vi), cap[0], op);
            errs = 0;
            for (int k = 0; k < snd; k++) if (cap[1 + k] != pay(vi, k)) errs++;
            check($sformatf("R5 payload order v%0d", vi), errs, 0);
            errs = 0;
            for (int k = 0; k < rcv; k++) if (cap[1 + snd + k] != 8'h00) errs++;
            check($sformatf("R5 mosi low in response v%0d", vi), errs, 0);
            check($sformatf("R7 sck phase v%0d", vi), hi_cnt, exp_half(code[3:0]) * 8 * (1 + snd + rcv));
            errs = 0;
            for (int k = 0; k < rcv; k++) begin
                rd(8'(8'h80 + ((snd + k) % 71)), v);
                if (v != rbyte(1 + snd + k)) errs++;
            end
            check($sformatf("R6 response placement v%0d", vi), errs, 0);
        end

        // R8 writes ignored while busy, R7 code 7
        begin
            logic [7:0] b0;
            rd(8'h80, b0);
            wr(8'h23, 8'h71);
            wr(8'h00, 8'h66);
            wr(8'h48, 8'd0);
            wr(8'h4B, 8'd0);
            mon_clr = 1'b1;
            @(negedge clk);
            mon_clr = 1'b0;
            wr(8'h02, 8'h01);
            wr(8'h00, 8'h77);
            wr(8'h48, 8'd9);
            wr(8'h80, 8'hEE);
            wr(8'h20, 8'h00);
            wr(8'h23, 8'h41);
            rd(8'h00, v); check("R8 opcode held while busy", v, 8'h66);
            rd(8'h02, v); check("R4 busy during slow transfer", v, 1);
            wait_idle(loops);
            rd(8'h00, v); check("R8 opcode after", v, 8'h66);
            rd(8'h48, v); check("R8 send count after", v, 0);
            rd(8'h80, v); check("R8 buffer slot0 after", v, b0);
            rd(8'h20, v); check("R8 enable after", v, 1);
            rd(8'h23, v); check("R8 rate after", v, 8'h71);
            check("R7 code 7 phase", hi_cnt, 125 * 8);
            check("R5 opcode-only edges", rises, 8);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule